// File: doc/BRIEF.md
# Dual-Mode Priority Interrupt Controller

The controller sits between eight request lines and the single interrupt input of a processor. A rising edge on a request line marks that line as waiting. The controller raises `intr_out` whenever a waiting request may be served now. The processor answers with a one-cycle `ack`, and in that cycle it takes the line number from `vec_out`. That line then becomes in service. Later a one-cycle `eos` pulse tells the controller that the handler has finished.

The `nest_mode` input picks one of two service policies at run time. With `nest_mode` low, the controller serves one interrupt at a time. Requests that arrive during a service are kept, and they are handed out strictly in the order in which they arrived. With `nest_mode` high, a waiting request with a strictly higher priority interrupts the current service. Line 0 has the highest priority and line 7 the lowest. The in-service bits then form a stack of interrupted levels. Each end of service retires the topmost (highest-priority) level, and the one below it shows again as in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `intr_out` is low and `isr_out` is all zero.
- R2: A 0-to-1 transition on `req_lines[i]` marks line i as waiting. The line stays waiting after its request input falls, until it is acknowledged. A request held high after its acknowledge creates no new request.
- R3: An `ack` in a cycle where `intr_out` is high hands out the line shown on `vec_out` (the 3-bit line number). That line stops waiting, and bit i of `isr_out` is set in the next cycle.
- R4: With `nest_mode` low, `intr_out` stays low while any `isr_out` bit is set. Requests that arrive meanwhile stay waiting and are served after the end of service.
- R5: With `nest_mode` low, waiting lines are presented in the order in which their requests arrived, regardless of priority.
- R6: With `nest_mode` low, requests that rise in the same cycle are queued in priority order (lower line number first).
- R7: With `nest_mode` high, a waiting line whose number is lower than every set `isr_out` bit drives `intr_out` high, and it can be acknowledged while the other service is still active.
- R8: With `nest_mode` high, a waiting line whose number is equal to or above the lowest set `isr_out` bit does not raise `intr_out`.
- R9: An `eos` clears only the lowest-numbered set bit of `isr_out`. The interrupted levels below it remain set.
- R10: With `nest_mode` high and nothing in service, `vec_out` shows the lowest-numbered waiting line.
- R11: An `ack` while `intr_out` is low has no effect. An `eos` while `isr_out` is zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| nest_mode | input | 1 | 0: one service at a time, arrival order; 1: nested priority preemption |
| req_lines | input | 8 | Request lines, rising-edge sensitive, line 0 highest priority |
| ack | input | 1 | Processor acknowledge, one cycle |
| eos | input | 1 | End of the current service, one cycle |
| intr_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 3 | Line number to be handed out, valid with `ack` |
| isr_out | output | 8 | In-service bit for each line |

## Verification
The bench makes a low-priority line arrive before a high-priority one in sequential mode. A controller that ranks by priority instead of arrival would hand out line 1 before line 5. The bench raises two lines in the same cycle to catch a queue that loses one of them or orders them by index the wrong way. In nested mode it tries an equal-level and a lower-level request against an active service, which exposes a comparison that uses less-or-equal where strictly-less is required. It also checks that two end-of-service pulses unwind the stack one level at a time, since a controller that cleared every bit would lose the preempted level. Stray `ack` and `eos` pulses and a request held high through its own service show whether the controller invents or drops work.

// File: rtl/prio_irq_pkg.sv
// Shared definitions for the priority interrupt controller.
// Assumes: the line count is fixed for a given build through the parameters below.
package prio_irq_pkg;
    localparam int unsigned NUM_LINES = 8;
    localparam int unsigned ID_W      = $clog2(NUM_LINES);

    typedef enum logic {
        POLICY_SEQ  = 1'b0,
        POLICY_NEST = 1'b1
    } policy_e;
endpackage

// File: rtl/prio_irq_pend.sv
// Edge detector and waiting-request register.
// Each rising edge on a line sets its waiting bit. A bit clears only when the
// processor acknowledges that line. accepted_o flags the edges that created a
// new waiting bit this cycle.
// Assumes: the request lines are already synchronous to clk.
module prio_irq_pend #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req_i,
    input  logic           clr_valid_i,
    input  logic [IDW-1:0] clr_id_i,
    output logic [N-1:0]   pending_o,
    output logic [N-1:0]   accepted_o
);
    logic [N-1:0] req_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] clr_mask;

    // Decode the acknowledged line into a clear mask.
    always_comb begin
        clr_mask = '0;
        if (clr_valid_i) clr_mask[clr_id_i] = 1'b1;
    end

    // New edges on lines that are not already waiting.
    assign accepted_o = req_i & ~req_q & ~pend_q;

    // Previous request levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // Waiting bits: set on an accepted edge, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | accepted_o;
    end

    assign pending_o = pend_q;

    // R2: a waiting bit never disappears without an acknowledge.
    assert_pend_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(clr_valid_i) |-> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/prio_irq_queue.sv
// Arrival-order queue of line numbers.
// Lines accepted in one cycle are appended lowest number first. An
// acknowledged line is removed from any position and the entries behind it
// close up.
// Assumes: a line is never pushed while it is already queued, so N slots always suffice.
module prio_irq_queue #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = $clog2(N),
    parameter int unsigned CW  = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   push_mask_i,
    input  logic           pop_valid_i,
    input  logic [IDW-1:0] pop_id_i,
    output logic [IDW-1:0] head_o,
    output logic           nonempty_o
);
    logic [IDW-1:0] slot_q [N];
    logic [IDW-1:0] slot_d [N];
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_d;
    logic           spill;

    // Remove the acknowledged line, then append the new arrivals.
    always_comb begin
        logic [CW-1:0] k;
        k     = '0;
        spill = 1'b0;
        for (int s = 0; s < int'(N); s++) slot_d[s] = '0;
        for (int s = 0; s < int'(N); s++) begin
            if (CW'(s) < cnt_q && !(pop_valid_i && slot_q[s] == pop_id_i)) begin
                slot_d[k[IDW-1:0]] = slot_q[s];
                k = k + 1'b1;
            end
        end
        for (int l = 0; l < int'(N); l++) begin
            if (push_mask_i[l]) begin
                if (k < CW'(N)) begin
                    slot_d[k[IDW-1:0]] = IDW'(l);
                    k = k + 1'b1;
                end else begin
                    spill = 1'b1;
                end
            end
        end
        cnt_d = k;
    end

    // Queue storage and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int s = 0; s < int'(N); s++) slot_q[s] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int s = 0; s < int'(N); s++) slot_q[s] <= slot_d[s];
        end
    end

    assign head_o     = slot_q[0];
    assign nonempty_o = (cnt_q != '0);

    // R2: no arrival is ever dropped for lack of space.
    assert_no_spill_R2: assert property (@(posedge clk) disable iff (!rst_n) !spill);
    // R6: the fill level stays within the slot count.
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(N));
endmodule

// File: rtl/prio_irq_sel.sv
// Selection logic: decides whether a request may be signalled, and which line.
// Sequential policy: the queue head, only while nothing is in service.
// Nested policy: the lowest-numbered waiting line, only if its number is
// below every line in service.
// Assumes: line 0 is the highest priority.
module prio_irq_sel #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = $clog2(N)
) (
    input  prio_irq_pkg::policy_e policy_i,
    input  logic [N-1:0]          pending_i,
    input  logic [N-1:0]          isr_i,
    input  logic [IDW-1:0]        head_i,
    input  logic                  nonempty_i,
    output logic                  irq_o,
    output logic [IDW-1:0]        vec_o
);
    logic [IDW-1:0] pend_top;
    logic [IDW-1:0] isr_top;

    // Lowest-numbered waiting line and lowest-numbered in-service line.
    always_comb begin
        pend_top = '0;
        isr_top  = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (pending_i[i]) pend_top = IDW'(i);
            if (isr_i[i])     isr_top  = IDW'(i);
        end
    end

    // Policy choice of request and vector.
    always_comb begin
        if (policy_i == prio_irq_pkg::POLICY_NEST) begin
            vec_o = pend_top;
            irq_o = (|pending_i) && ((isr_i == '0) || (pend_top < isr_top));
        end else begin
            vec_o = head_i;
            irq_o = nonempty_i && (isr_i == '0);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Dual-mode priority interrupt controller, top level.
// Connects the waiting-request register, the arrival queue and the selection
// logic, and holds the in-service bits. A qualified ack sets the handed-out
// line in service. A qualified eos clears the lowest-numbered in-service bit.
// Assumes: ack and eos are single-cycle pulses that are synchronous to clk.
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nest_mode,
    input  logic [NUM_LINES-1:0] req_lines,
    input  logic                 ack,
    input  logic                 eos,
    output logic                 intr_out,
    output logic [ID_W-1:0]      vec_out,
    output logic [NUM_LINES-1:0] isr_out
);
    localparam int unsigned N = NUM_LINES;

    logic [N-1:0]    pending;
    logic [N-1:0]    accepted;
    logic [N-1:0]    isr_q;
    logic [N-1:0]    isr_set;
    logic [N-1:0]    isr_clr;
    logic [ID_W-1:0] q_head;
    logic            q_nonempty;
    logic            ack_fire;
    logic            eos_fire;
    policy_e         policy;

    assign policy   = policy_e'(nest_mode);
    assign ack_fire = ack && intr_out;
    assign eos_fire = eos && (isr_q != '0);

    prio_irq_pend #(.N(N), .IDW(ID_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_lines),
        .clr_valid_i(ack_fire),
        .clr_id_i   (vec_out),
        .pending_o  (pending),
        .accepted_o (accepted)
    );

    prio_irq_queue #(.N(N), .IDW(ID_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_mask_i(accepted),
        .pop_valid_i(ack_fire),
        .pop_id_i   (vec_out),
        .head_o     (q_head),
        .nonempty_o (q_nonempty)
    );

    prio_irq_sel #(.N(N), .IDW(ID_W)) u_sel (
        .policy_i  (policy),
        .pending_i (pending),
        .isr_i     (isr_q),
        .head_i    (q_head),
        .nonempty_i(q_nonempty),
        .irq_o     (intr_out),
        .vec_o     (vec_out)
    );

    // Set mask from the acknowledged line, clear mask for the topmost level.
    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        if (ack_fire) isr_set[vec_out] = 1'b1;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (isr_q[i]) isr_clr = N'(1) << i;
        end
        if (!eos_fire) isr_clr = '0;
    end

    // In-service bits, one per line.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr) | isr_set;
    end

    assign isr_out = isr_q;

    // R4: sequential policy never signals while a service is active.
    assert_seq_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_mode && isr_q != '0) |-> !intr_out);
    // R3: an accepted acknowledge puts its line in service.
    assert_ack_in_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> isr_q[$past(vec_out)]);
    // R9: end of service retires exactly one level.
    assert_eos_one_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_fire && !ack_fire) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
    // R11: a stray acknowledge with no eos leaves the in-service bits unchanged.
    assert_stray_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !intr_out && !eos) |=> (isr_q == $past(isr_q)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nest_mode = 1'b0;
    logic [7:0] req_lines = '0;
    logic       ack = 1'b0;
    logic       eos = 1'b0;
    logic       intr_out;
    logic [2:0] vec_out;
    logic [7:0] isr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .req_lines(req_lines),
        .ack(ack), .eos(eos), .intr_out(intr_out), .vec_out(vec_out), .isr_out(isr_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_req(input logic [7:0] m);
        req_lines = m;
        step();
        req_lines = '0;
    endtask

    // Acknowledge with an expected vector, then check the in-service bit.
    task automatic do_ack(input string req, input int exp_vec);
        check(req, "intr before ack", int'(intr_out), 1);
        check(req, "vector", int'(vec_out), exp_vec);
        ack = 1'b1;
        step();
        ack = 1'b0;
        check("R3", "isr bit after ack", int'(isr_out[exp_vec]), 1);
    endtask

    task automatic do_eos();
        eos = 1'b1;
        step();
        eos = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "intr after reset", int'(intr_out), 0);
        check("R1", "isr after reset", int'(isr_out), 0);
    endtask

    task automatic t_seq_order();
        nest_mode = 1'b0;
        pulse_req(8'h20);             // line 5 first
        step();
        pulse_req(8'h02);             // line 1 later
        step();
        check("R2", "intr kept after req fell", int'(intr_out), 1);
        do_ack("R5", 5);
        check("R4", "intr while busy", int'(intr_out), 0);
        pulse_req(8'h01);             // line 0 arrives during service
        check("R4", "intr still low with new arrival", int'(intr_out), 0);
        do_eos();
        check("R9", "isr after eos", int'(isr_out), 0);
        do_ack("R5", 1);
        do_eos();
        do_ack("R4", 0);
        do_eos();
        check("R5", "queue drained", int'(intr_out), 0);
    endtask

    task automatic t_seq_simul();
        nest_mode = 1'b0;
        pulse_req(8'h84);             // lines 2 and 7 together
        pulse_req(8'h01);             // line 0 after them
        do_ack("R6", 2);
        do_eos();
        do_ack("R6", 7);
        do_eos();
        do_ack("R6", 0);
        do_eos();
        check("R6", "all served", int'(intr_out), 0);
    endtask

    task automatic t_nest();
        nest_mode = 1'b1;
        pulse_req(8'h10);             // line 4
        do_ack("R10", 4);
        pulse_req(8'h40);             // lower priority line 6
        check("R8", "lower does not preempt", int'(intr_out), 0);
        pulse_req(8'h10);             // same line 4 again
        check("R8", "equal does not preempt", int'(intr_out), 0);
        pulse_req(8'h02);             // line 1 preempts
        check("R7", "higher raises intr", int'(intr_out), 1);
        do_ack("R7", 1);
        check("R7", "stack of two", int'(isr_out), 8'h12);
        do_eos();
        check("R9", "returns to level 4", int'(isr_out), 8'h10);
        check("R8", "no preempt after return", int'(intr_out), 0);
        do_eos();
        check("R9", "stack empty", int'(isr_out), 0);
        do_ack("R10", 4);
        do_eos();
        do_ack("R10", 6);
        do_eos();
        check("R10", "nested drained", int'(intr_out), 0);
    endtask

    task automatic t_ignore();
        nest_mode = 1'b0;
        ack = 1'b1;
        step();
        ack = 1'b0;
        check("R11", "stray ack isr", int'(isr_out), 0);
        do_eos();
        check("R11", "stray eos isr", int'(isr_out), 0);
        check("R11", "stray eos intr", int'(intr_out), 0);
        req_lines = 8'h08;            // held high through its service
        step();
        do_ack("R2", 3);
        do_eos();
        step();
        check("R2", "held level no new request", int'(intr_out), 0);
        req_lines = '0;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_seq_order();
        t_seq_simul();
        t_nest();
        t_ignore();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule